// File: doc/BRIEF.md
# Prescaled Down-Counting Timer Channel

This block is one channel of a general-purpose timer. A down counter is loaded from a programmable interval. It steps once per prescaled tick. The tick comes from one of four tick-enable inputs, one cycle wide each, divided by a power of two between 1 and 128. A control byte sets the source, the divider, the run state and the mode. In periodic mode the channel refills itself from the interval each time it expires. In one-shot mode it stops at zero and clears its own run bit, so the control value that is read back shows that the channel has stopped.

The surrounding logic writes the control byte and the interval through separate strobes, each with its own data. It samples `count_o` and treats the one-cycle `expire_o` pulse as the status event for this channel. All state is clocked on `clk_i`. The tick inputs are synchronous enables, not separate clocks.

Control byte layout: bit 0 is run, bit 1 is reload-on-write, bits [3:2] are the source select, bits [6:4] are the prescale exponent p, and bit 7 is one-shot.

Top module: `prescaled_timer_chan`

## Requirements
- R1: After reset `count_o` is 0, `expire_o` is 0 and `ctrl_o` is 8'h04 (source 1, p = 0, stopped, periodic).
- R2: Control bits [3:2] select which bit of `src_tick_i` drives the channel. Pulses on the other three bits have no effect on `count_o`.
- R3: With control bits [6:4] = p, the counter steps once for every 2^p pulses of the selected source. A control write restarts the division, so the first step comes on the 2^p-th selected pulse after the write.
- R4: While control bit 0 (run) is 0, `count_o` holds its value unless a load occurs.
- R5: A control write with bit 1 set loads the counter with the stored interval. The written byte, including bit 1, is stored and shown on `ctrl_o`.
- R6: An interval write loads the counter with the written value in the next cycle. If a reload control write falls in the same cycle, the newly written interval value wins.
- R7: A step taken while the count is 1 is an expiry. `expire_o` is high for exactly the one cycle in which `count_o` first shows the post-expiry value.
- R8: When control bit 7 is 0 (periodic), an expiry loads the stored interval into the counter and the channel keeps running.
- R9: When control bit 7 is 1 (one-shot), an expiry leaves the count at 0 and clears bit 0 of `ctrl_o` in the same cycle. No further steps or expiries follow.
- R10: A count of 0 never steps and never expires, even while the channel is running.
- R11: A cycle carrying a control or interval write takes no count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| intv_we_i | input | 1 | Interval write strobe |
| intv_wdata_i | input | CNT_W | Interval write data |
| src_tick_i | input | 4 | Tick enables of the four selectable sources |
| ctrl_o | output | 8 | Current control byte, including the hardware-cleared run bit |
| count_o | output | CNT_W | Current counter value |
| expire_o | output | 1 | One-cycle expiry pulse |

## Verification
The case that is hardest to reach from the ports is the prescaler phase. Its divide counter cannot be seen and keeps running across writes that leave run set, so a step is only predictable if that counter is known to be at a fixed point. The stimulus gets there by issuing a fresh control write, which restarts the division. It then holds the selected source high every cycle, so the first step lands on exactly the 2^p-th edge. The largest exponent is included, with a wait of 128 cycles. The one-shot stop and the same-cycle reload and interval write are also placed on exact edges, after the counter is driven to known values.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SRC_W   = 2;
  localparam int N_SRC   = 1 << SRC_W;
  localparam int PSC_W   = 3;
  localparam int PSC_CW  = (1 << PSC_W) - 1;
  localparam int CTRL_W  = 3 + SRC_W + PSC_W;

  typedef struct packed {
    logic             oneshot;
    logic [PSC_W-1:0] psc;
    logic [SRC_W-1:0] src;
    logic             reload;
    logic             run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{oneshot: 1'b0, psc: '0, src: SRC_W'(1),
                                 reload: 1'b0, run: 1'b0};
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  ctrl_t wdata_i,
  input  logic  stop_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (we_i)    ctrl_q <= wdata_i;
    else if (stop_i)  ctrl_q.run <= 1'b0;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic [SRC_W-1:0] sel_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_CW-1:0] div_q;
  logic [PSC_CW-1:0] mask;
  logic              src_tick;

  assign src_tick = src_tick_i[sel_i];

  // low p bits of the divider form the phase
  for (genvar i = 0; i < PSC_CW; i++) begin : g_mask
    assign mask[i] = (PSC_W'(i) < psc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (clear_i)   div_q <= '0;
    else if (src_tick)  div_q <= div_q + 1'b1;
  end

  assign tick_o = !clear_i && src_tick && ((div_q & mask) == mask);
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] refill_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             expire_q;
  logic             live;

  assign live   = step_i && !load_i && (cnt_q != '0);
  assign fire_o = live && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= fire_o;
      if (load_i)       cnt_q <= load_val_i;
      else if (fire_o)  cnt_q <= periodic_i ? refill_i : '0;
      else if (live)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign expire_o = expire_q;
endmodule

// File: rtl/prescaled_timer_chan.sv
module prescaled_timer_chan
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              intv_we_i,
  input  logic [CNT_W-1:0]  intv_wdata_i,
  input  logic [N_SRC-1:0]  src_tick_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              expire_o
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_wr;
  logic [CNT_W-1:0] intv_q;
  logic             ptick;
  logic             fire;
  logic             load;
  logic [CNT_W-1:0] load_val;

  assign ctrl_wr = ctrl_t'(ctrl_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         intv_q <= '0;
    else if (intv_we_i)  intv_q <= intv_wdata_i;
  end

  tmr_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wr),
    .stop_i  (fire && ctrl_q.oneshot),
    .ctrl_o  (ctrl_q)
  );

  tmr_prescaler u_psc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (ctrl_we_i || !ctrl_q.run),
    .src_tick_i (src_tick_i),
    .sel_i      (ctrl_q.src),
    .psc_i      (ctrl_q.psc),
    .tick_o     (ptick)
  );

  // interval write data beats a same-cycle reload
  assign load     = intv_we_i || (ctrl_we_i && ctrl_wr.reload);
  assign load_val = intv_we_i ? intv_wdata_i : intv_q;

  tmr_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .step_i     (ptick && !ctrl_we_i && !intv_we_i),
    .periodic_i (!ctrl_q.oneshot),
    .refill_i   (intv_q),
    .cnt_o      (count_o),
    .fire_o     (fire),
    .expire_o   (expire_o)
  );

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/prescaled_timer_chan_chk.sv
module prescaled_timer_chan_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [7:0]       ctrl_wdata_i,
  input logic             intv_we_i,
  input logic [CNT_W-1:0] intv_wdata_i,
  input logic [7:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             expire_o,
  input logic [CNT_W-1:0] intv_q
);
  AST_INTV_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_we_i |=> count_o == $past(intv_wdata_i)); // R6
  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[1] && !intv_we_i) |=> count_o == $past(intv_q)); // R5
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[0] && !ctrl_we_i && !intv_we_i) |=> $stable(count_o)); // R4
  AST_EXPIRE_FROM_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> $past(count_o) == CNT_W'(1)); // R7
  AST_PERIODIC_REFILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !ctrl_o[7]) |-> count_o == intv_q); // R8
  AST_ONESHOT_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && ctrl_o[7]) |-> (count_o == '0 && !ctrl_o[0])); // R9
  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && !ctrl_we_i && !intv_we_i) |=> (count_o == '0 && !expire_o)); // R10
  AST_NO_STEP_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_wdata_i[1] && !intv_we_i) |=> $stable(count_o)); // R11
endmodule

bind prescaled_timer_chan prescaled_timer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .intv_we_i    (intv_we_i),
  .intv_wdata_i (intv_wdata_i),
  .ctrl_o       (ctrl_o),
  .count_o      (count_o),
  .expire_o     (expire_o),
  .intv_q       (intv_q)
);

// File: tb/sim_prescaled_timer_chan.sv
`timescale 1ns/1ps
module sim_prescaled_timer_chan;
  localparam int CNT_W = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ctrl_we_i = 1'b0;
  logic [7:0]       ctrl_wdata_i = '0;
  logic             intv_we_i = 1'b0;
  logic [CNT_W-1:0] intv_wdata_i = '0;
  logic [3:0]       src_tick_i = '0;
  logic [7:0]       ctrl_o;
  logic [CNT_W-1:0] count_o;
  logic             expire_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_timer_chan #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .intv_we_i(intv_we_i), .intv_wdata_i(intv_wdata_i),
    .src_tick_i(src_tick_i),
    .ctrl_o(ctrl_o), .count_o(count_o), .expire_o(expire_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_cnt(input string req, input longint exp);
    check(count_o == exp, req, count_o, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    cyc(1);
    ctrl_we_i = 1'b0;
  endtask

  task automatic wr_intv(input logic [CNT_W-1:0] v);
    intv_we_i = 1'b1; intv_wdata_i = v;
    cyc(1);
    intv_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk_cnt("R1 count", 0);
    check(ctrl_o == 8'h04, "R1 ctrl", ctrl_o, 8'h04);
    check(expire_o == 1'b0, "R1 expire", expire_o, 0);
  endtask

  task automatic t_intv_hold;
    src_tick_i = 4'b0010;
    wr_intv(5);
    chk_cnt("R6 interval load", 5);
    cyc(3);
    chk_cnt("R4 hold while stopped", 5);
  endtask

  task automatic t_periodic;
    src_tick_i = 4'b0010;
    wr_intv(3);
    wr_ctrl(8'h05);
    chk_cnt("R11 write cycle no step", 3);
    cyc(1); chk_cnt("R8 step", 2);
    cyc(1); chk_cnt("R8 step", 1);
    check(expire_o == 1'b0, "R7 no early expire", expire_o, 0);
    cyc(1);
    chk_cnt("R8 refill", 3);
    check(expire_o == 1'b1, "R7 expire pulse", expire_o, 1);
    cyc(1);
    chk_cnt("R8 keeps running", 2);
    check(expire_o == 1'b0, "R7 pulse one cycle", expire_o, 0);
  endtask

  task automatic t_source;
    src_tick_i = 4'b1101;
    wr_intv(10);
    wr_ctrl(8'h05);
    cyc(5);
    chk_cnt("R2 unselected sources ignored", 10);
    src_tick_i = 4'b0001;
    wr_ctrl(8'h01);
    cyc(4);
    chk_cnt("R2 source 0 selected", 6);
  endtask

  task automatic t_prescale;
    src_tick_i = 4'b0010;
    wr_intv(100);
    wr_ctrl(8'h25);
    cyc(3); chk_cnt("R3 p=2 before 4th tick", 100);
    cyc(1); chk_cnt("R3 p=2 at 4th tick", 99);
    cyc(4); chk_cnt("R3 p=2 second step", 98);
    wr_ctrl(8'h75);
    cyc(127); chk_cnt("R3 p=7 before 128th tick", 98);
    cyc(1); chk_cnt("R3 p=7 at 128th tick", 97);
  endtask

  task automatic t_reload;
    src_tick_i = 4'b0010;
    wr_ctrl(8'h04);
    wr_intv(50);
    wr_ctrl(8'h05);
    cyc(5);
    chk_cnt("R4 running steps", 45);
    wr_ctrl(8'h06);
    chk_cnt("R5 reload from interval", 50);
    check(ctrl_o == 8'h06, "R5 ctrl stored", ctrl_o, 8'h06);
    cyc(2);
    chk_cnt("R4 reload without run holds", 50);
    ctrl_we_i = 1'b1; ctrl_wdata_i = 8'h06;
    intv_we_i = 1'b1; intv_wdata_i = 77;
    cyc(1);
    ctrl_we_i = 1'b0; intv_we_i = 1'b0;
    chk_cnt("R6 interval data wins", 77);
  endtask

  task automatic t_oneshot;
    src_tick_i = 4'b0010;
    wr_intv(2);
    wr_ctrl(8'h85);
    chk_cnt("R9 start", 2);
    cyc(1); chk_cnt("R9 step", 1);
    cyc(1);
    chk_cnt("R9 ends at zero", 0);
    check(expire_o == 1'b1, "R9 expire", expire_o, 1);
    check(ctrl_o == 8'h84, "R9 run cleared", ctrl_o, 8'h84);
    cyc(3);
    chk_cnt("R9 stays zero", 0);
    check(expire_o == 1'b0, "R9 no re-expire", expire_o, 0);
  endtask

  task automatic t_zero;
    bit seen = 1'b0;
    src_tick_i = 4'b0010;
    wr_intv(0);
    wr_ctrl(8'h05);
    for (int i = 0; i < 10; i++) begin
      if (expire_o) seen = 1'b1;
      cyc(1);
    end
    chk_cnt("R10 zero holds", 0);
    check(!seen, "R10 zero never expires", seen, 0);
  endtask

  task automatic t_write_no_step;
    src_tick_i = 4'b0010;
    wr_intv(20);
    wr_ctrl(8'h05);
    cyc(2);
    chk_cnt("R11 pre", 18);
    wr_ctrl(8'h05);
    chk_cnt("R11 no step on ctrl write", 18);
    cyc(1);
    chk_cnt("R11 resumes", 17);
    wr_intv(30);
    chk_cnt("R11 no step on interval write", 30);
  endtask

  initial begin
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
    t_reset();
    t_intv_hold();
    t_periodic();
    t_source();
    t_prescale();
    t_reload();
    t_oneshot();
    t_zero();
    t_write_no_step();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule